// File: doc/BRIEF.md
# GCI Line Activation Sequencer

This block sits on the layer-2 side of a GCI serial link and handles the activation and deactivation handshake with the layer-1 device. It watches the bus data clock. When no clock edge arrives for a set number of reference cycles, the block declares the line deactivated. While deactivated and not forced, the transmit line rests at logic one.

Each bit of the frame lasts two data-clock periods, and a sync pulse seen at a rising edge marks the start of the frame. The block picks the 4-bit C/I field of channel 0 out of each received frame. A code becomes a valid indication once it has arrived in two consecutive frames and differs from the code already reported. A new valid indication updates the status word and raises a maskable interrupt request, which stays pending until the host acknowledges it.

To wake the line, the host sets a force-zero control. The transmit output then stays at zero for the whole frame, so the C/I field carries the timing command, code 0000, in every frame. Once the layer-1 device restarts the clock and reports an indication, the host clears force-zero. Normal output then resumes: the host's command code goes out in the C/I field and the serial payload goes out everywhere else.

Top module: `gci_wake_seq`

## Requirements
- R1: After reset, `status` reads {pending=0, deactivated=1, code=4'hF}, `irq` is 0 and `txd` is 1.
- R2: After LOSS_CYC reference cycles with no `dclk` transition, the deactivated flag is set and the reported code returns to 4'hF. Any later `dclk` transition clears the flag on the next cycle.
- R3: While deactivated with `force_zero` low, `txd` is 1.
- R4: While `force_zero` is high, `txd` is 0 for every bit of every frame, so the C/I field carries the timing command 4'b0000, whether or not clocks run.
- R5: `fsync` high at a `dclk` rising edge starts bit 0 of a frame. Each bit spans two `dclk` rising edges, and `rxd` is sampled at the second of them. Frames are FRAME_BITS bits long, and the C/I field is bits CI_POS..CI_POS+3, sent most significant bit first.
- R6: With clocks running, `force_zero` low and the frame synchronised, `txd` carries `cmd_code` (MSB first) in the C/I field and `tx_data` in every other bit.
- R7: A received C/I code becomes valid when it arrives in two consecutive frames and differs from the code currently reported. `status[3:0]` then takes that code and the pending flag `status[5]` is set. Codes that alternate from frame to frame never become valid.
- R8: `irq` equals pending and not `irq_mask`. The mask never stops the status code or the pending flag from updating.
- R9: The pending flag stays set until `irq_ack` is sampled high. A new indication in the same cycle as the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk | input | 1 | GCI data clock, sampled by clk |
| fsync | input | 1 | GCI frame sync |
| rxd | input | 1 | Receive serial data from layer 1 |
| tx_data | input | 1 | Outgoing serial payload for bits outside the C/I field |
| force_zero | input | 1 | Host control: force transmit line low and send the timing command |
| cmd_code | input | 4 | C/I command sent when not forcing |
| irq_mask | input | 1 | Interrupt mask |
| irq_ack | input | 1 | Clears the pending indication |
| txd | output | 1 | Transmit serial data |
| irq | output | 1 | Interrupt request |
| status | output | 6 | {pending, deactivated, valid C/I code[3:0]} |

## Verification
The assertions take three things for granted. Every input is synchronous to `clk`. Each `dclk` level lasts at least one reference cycle. `dclk` toggles far more often than once per LOSS_CYC cycles while the bus is active. The stimulus holds each `dclk` level for two reference cycles and changes inputs only at falling edges of `clk`. It lets the clock stop only in deliberate gaps that run longer than the loss window. Frames always begin with `fsync` at the first rising edge of bit 0, so the block never sees a misaligned sync.

// File: rtl/gci_wake_seq.sv
module gci_wake_seq #(
  parameter int FRAME_BITS = 16,
  parameter int CI_POS     = 8,
  parameter int LOSS_CYC   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dclk,
  input  logic       fsync,
  input  logic       rxd,
  input  logic       tx_data,
  input  logic       force_zero,
  input  logic [3:0] cmd_code,
  input  logic       irq_mask,
  input  logic       irq_ack,
  output logic       txd,
  output logic       irq,
  output logic [5:0] status
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int CW = $clog2(LOSS_CYC + 1);
  localparam logic [BW-1:0] CI_LO = BW'(CI_POS);
  localparam logic [BW-1:0] CI_HI = BW'(CI_POS + 3);
  localparam logic [BW-1:0] LAST  = BW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYC - 1);

  logic          dclk_q, ph, synced, deact, prev_ok, pend;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] idle;
  logic [3:0]    sh, prev_code, ci_code;

  wire       rise     = dclk & ~dclk_q;
  wire       dclk_tgl = dclk ^ dclk_q;
  wire       in_ci    = synced && (bcnt >= CI_LO) && (bcnt <= CI_HI);
  wire [1:0] ci_idx   = 2'(bcnt - CI_LO);
  wire       cmd_bit  = cmd_code[2'd3 - ci_idx];
  wire [3:0] code_now = {sh[2:0], rxd};
  wire       ci_end   = rise && ph && synced && !fsync && (bcnt == CI_HI);
  wire       new_ind  = ci_end && prev_ok && (code_now == prev_code) && (code_now != ci_code);

  assign txd    = force_zero ? 1'b0 : (deact || !synced) ? 1'b1 : in_ci ? cmd_bit : tx_data;
  assign irq    = pend & ~irq_mask;
  assign status = {pend, deact, ci_code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dclk_q    <= 1'b0;
      ph        <= 1'b0;
      synced    <= 1'b0;
      bcnt      <= LAST;
      idle      <= '0;
      deact     <= 1'b1;
      prev_ok   <= 1'b0;
      prev_code <= 4'hF;
      sh        <= 4'h0;
      ci_code   <= 4'hF;
      pend      <= 1'b0;
    end else begin
      dclk_q <= dclk;
      if (dclk_tgl) begin
        idle  <= '0;
        deact <= 1'b0;
      end else if (!deact) begin
        if (idle == LIMIT) begin
          deact   <= 1'b1;
          synced  <= 1'b0;
          prev_ok <= 1'b0;
          ci_code <= 4'hF;
        end else begin
          idle <= idle + 1'b1;
        end
      end
      if (rise) begin
        if (fsync) begin
          bcnt   <= '0;
          ph     <= 1'b1;
          synced <= 1'b1;
        end else if (!ph) begin
          bcnt <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
          ph   <= 1'b1;
        end else begin
          ph <= 1'b0;
          if (in_ci) sh <= code_now;
          if (ci_end) begin
            prev_code <= code_now;
            prev_ok   <= 1'b1;
          end
        end
      end
      if (new_ind) ci_code <= code_now;
      if (new_ind) pend <= 1'b1;
      else if (irq_ack) pend <= 1'b0;
    end
  end

  p_loss_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deact) |-> $past(idle) == LIMIT);
  p_resume_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_tgl |=> !deact);
  p_idle_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (deact && !force_zero) |-> txd);
  p_code_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ci_code) && !deact) |-> pend);
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !irq_ack) |=> pend);
endmodule

// File: tb/gci_wake_seq_bench.sv
module gci_wake_seq_bench;
  localparam int FB = 16, CP = 8, LC = 32;
  logic clk = 0, rst_n = 0, dclk = 0, fsync = 0, rxd = 1, tx_data = 0;
  logic force_zero = 0, irq_mask = 0, irq_ack = 0;
  logic [3:0] cmd_code = 4'h0;
  logic txd, irq;
  logic [5:0] status;
  int checks = 0, errors = 0;
  logic [3:0] exp_code;

  always #4 clk = ~clk;

  gci_wake_seq #(.FRAME_BITS(FB), .CI_POS(CP), .LOSS_CYC(LC)) u_gci_wake_seq (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .fsync(fsync), .rxd(rxd), .tx_data(tx_data),
    .force_zero(force_zero), .cmd_code(cmd_code), .irq_mask(irq_mask), .irq_ack(irq_ack),
    .txd(txd), .irq(irq), .status(status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame: rx C/I field carries rxc; returns number of txd bit mismatches
  task automatic frame(input logic [3:0] rxc, output int bad);
    bad = 0;
    for (int k = 0; k < FB; k++) begin
      logic inci, exp_b;
      inci = (k >= CP) && (k < CP + 4);
      tx_data = (k % 3 == 0);
      rxd = inci ? rxc[3 - (k - CP)] : 1'b1;
      fsync = (k == 0); dclk = 1; wait_n(2);
      fsync = 0; dclk = 0; wait_n(2);
      dclk = 1; wait_n(2);
      exp_b = force_zero ? 1'b0 : inci ? cmd_code[3 - (k - CP)] : tx_data;
      if (txd !== exp_b) bad++;
      dclk = 0; wait_n(2);
    end
  endtask

  task automatic ack();
    irq_ack = 1; wait_n(1); irq_ack = 0; wait_n(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    wait_n(3); rst_n = 1; wait_n(1);
    chk(status == 6'b01_1111, "R1 status", status, 6'h1F);
    chk(irq == 0 && txd == 1, "R1 irq/txd", {irq, txd}, 2'b01);
    exp_code = 4'hF;

    cmd_code = 4'hA;
    frame(4'hF, bad); chk(bad == 0, "R6 tx frame", bad, 0);
    chk(status[4] == 0, "R2 clock resume", status[4], 0);
    frame(4'hF, bad); chk(bad == 0, "R5 R6 tx frame", bad, 0);

    frame(4'h3, bad);
    chk(status[3:0] == 4'hF && !status[5], "R7 single frame not valid", status, 6'h0F);
    frame(4'h3, bad);
    chk(status[3:0] == 4'h3 && status[5] && irq, "R7 two frames valid", status, 6'h23);
    exp_code = 4'h3;
    frame(4'h3, bad);
    chk(status[5] && irq, "R9 pending held", status[5], 1);
    ack();
    chk(!status[5] && !irq, "R9 ack clears", status[5], 0);

    irq_mask = 1;
    frame(4'h5, bad); frame(4'h5, bad);
    chk(status == 6'b10_0101 && !irq, "R8 masked status update", {irq, status}, 7'h25);
    irq_mask = 0; wait_n(1);
    chk(irq, "R8 unmask raises irq", irq, 1);
    ack();
    exp_code = 4'h5;

    for (int i = 0; i < 4; i++) frame((i % 2) ? 4'h7 : 4'h6, bad);
    chk(status == {2'b00, exp_code}, "R7 alternating codes ignored", status, exp_code);

    for (int c = 0; c < 16; c++) begin
      int b1, b2;
      logic pe;
      cmd_code = 4'(c);
      frame(4'(c), b1); frame(4'(c), b2);
      chk(b1 + b2 == 0, "R6 command sweep", b1 + b2, 0);
      pe = (4'(c) != exp_code);
      chk(status == {pe, 1'b0, 4'(c)}, "R7 indication sweep", status, {pe, 1'b0, 4'(c)});
      exp_code = 4'(c);
      ack();
    end

    // clock stop
    wait_n(LC / 2);
    chk(status[4] == 0, "R2 not yet lost", status[4], 0);
    wait_n(LC);
    chk(status[4] == 1 && status[3:0] == 4'hF, "R2 clock loss", status, 6'h1F);
    chk(txd == 1, "R3 idle line", txd, 1);

    // host activation
    force_zero = 1; wait_n(1);
    chk(txd == 0, "R4 force while stopped", txd, 0);
    cmd_code = 4'h9;
    frame(4'hC, bad); chk(bad == 0, "R4 TIM frame 1", bad, 0);
    chk(status[4] == 0, "R2 resume", status[4], 0);
    frame(4'hC, bad); chk(bad == 0, "R4 TIM frame 2", bad, 0);
    chk(status == 6'b10_1100 && irq, "R7 activation indication", status, 6'h2C);
    frame(4'hC, bad); chk(bad == 0, "R4 TIM frame 3", bad, 0);
    ack();
    force_zero = 0;
    frame(4'hC, bad); chk(bad == 0, "R6 release to normal data", bad, 0);
    chk(!irq && status == 6'b00_1100, "R9 no re-trigger", status, 6'h0C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule